// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block decides a conditional branch over a vector of condition fields. After a `start` pulse it steps through the elements of the vector, one element per cycle. It presents the index of the current element and reads back that element's 4-bit condition field and its predicate bit. From each active element it takes a single test outcome: the selected bit of the field compared with a wanted value. It then merges the outcomes with set logic. In ALL mode every active outcome must hold. In SOME mode at least one must hold.

Three options sit on top of the set decision. Counted-decrement mode lowers the loop counter once for each element that meets a condition, and it can count masked-out elements as well. Truncate mode stops the scan at the first active element whose outcome matches a chosen stop value and reports a shortened vector length. Link mode exchanges the loop-state register with its own link register and loads the ordinary link register with the next instruction address. All of these writes are held until the decision is final, and they happen only when the branch is taken. With one element and all options off, the result equals a plain scalar conditional branch. The optional scalar counter decrement-and-test is part of that scalar behaviour.

Top module: `vbranch_eval`

## Requirements
- R1: An element outcome is true when bit `bit_sel` of `elem_cr` (bit 0 = LSB) equals `want_val`. When `use_cr` is 0, every outcome is true.
- R2: With `all_mode`=1, `taken` needs every active evaluated element's outcome to be true. An empty active set gives taken.
- R3: With `all_mode`=0 (SOME), `taken` needs at least one active evaluated element with a true outcome. An empty active set gives not taken.
- R4: An element whose `elem_pred` is 0 has no effect on the set decision, whatever its condition field holds.
- R5: Scalar behaviour holds with `vl_in`=1 and `ctr_mode`, `vli_mode` and `link_en` all 0. If `dec_ctr`=1, the counter becomes `ctr_in`-1 (modulo 2^CW), `ctr_we`=1, and taken also needs that new value to be non-zero. If `dec_ctr`=0, `ctr_we`=0.
- R6: With `vli_mode`=1, the scan ends at the first active element whose outcome equals `vli_stop_ok`. `vl_we`=1, and `vl_out` is that element's index, or the index plus one when `vli_incl`=1. Later elements are not evaluated. If no element matches, `vl_we`=0 and `vl_out` is the effective length.
- R7: With `ctr_mode`=1, `ctr_out` is `ctr_in` minus the count of active elements with a true outcome, plus the count of masked-out elements when `ctr_masked`=1. `ctr_we`=1, no counter-zero test applies, and `dec_ctr` is ignored.
- R8: When `link_en`=1 and the branch is taken, `lr_we`, `llr_we` and `lst_we` pulse together with `done`. They carry `lr_data`=`nia_in`, `llr_data`=`lst_in` and `lst_data`=`llr_in`. A non-taken branch raises none of them.
- R9: Element i is requested on `elem_idx` in the i-th cycle after the start edge. `done` pulses for one cycle after the edge that evaluates the last element. A zero length gives `done` one cycle after start. `vl_in` above MAXVL is treated as MAXVL, and `start` is ignored while `busy`.
- R10: After reset, `busy`, `done` and all write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch the configuration and begin a scan |
| vl_in | input | VLW | Vector length, clamped to MAXVL |
| all_mode | input | 1 | 1 = ALL, 0 = SOME |
| want_val | input | 1 | Wanted value of the selected bit |
| use_cr | input | 1 | 0 makes every outcome true |
| bit_sel | input | SW | Bit of the condition field to test |
| ctr_mode | input | 1 | Counted-decrement mode |
| ctr_masked | input | 1 | Counted mode also counts masked-out elements |
| dec_ctr | input | 1 | Scalar decrement-and-test of the counter |
| vli_mode | input | 1 | Length-truncate mode |
| vli_stop_ok | input | 1 | Outcome value that stops the scan |
| vli_incl | input | 1 | Include the stopping element in the new length |
| link_en | input | 1 | Perform the paired link update when taken |
| ctr_in | input | CW | Counter value |
| nia_in | input | AW | Next instruction address |
| lst_in | input | AW | Current loop-state value |
| llr_in | input | AW | Current loop-state link value |
| elem_cr | input | FW | Condition field of element `elem_idx` |
| elem_pred | input | 1 | Predicate bit of element `elem_idx` |
| busy | output | 1 | Scan in progress |
| elem_idx | output | VLW | Index of the element requested |
| done | output | 1 | Result valid (one-cycle pulse) |
| taken | output | 1 | Branch decision |
| ctr_we | output | 1 | Counter write enable |
| ctr_out | output | CW | New counter value |
| vl_we | output | 1 | Length write enable |
| vl_out | output | VLW | New vector length |
| lr_we | output | 1 | Ordinary link register write enable |
| lr_data | output | AW | Ordinary link register data |
| llr_we | output | 1 | Loop-state link register write enable |
| llr_data | output | AW | Loop-state link register data |
| lst_we | output | 1 | Loop-state register write enable |
| lst_data | output | AW | Loop-state register data |

## Verification
The hardest case to reach is a truncate-mode stop on an element whose predicate is set, placed after masked-out elements that would themselves have matched the stop value. Counted-decrement mode and the link swap are active in the same scan. Only that mix shows whether masked elements are kept out of truncation while still feeding the counter, and whether the decision uses exactly the elements up to the stop point. Directed scans build this case from chosen per-element bit and predicate masks. A run of seeded random scans then varies length, mode bits and patterns, so many such alignments occur. A reference model predicts every cycle's `done`, `elem_idx` and result fields from those masks.

// File: rtl/vbranch_eval.sv
module vbranch_eval #(
  parameter int MAXVL = 64,
  parameter int CW    = 16,
  parameter int AW    = 32,
  parameter int FW    = 4,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int SW   = (FW > 1) ? $clog2(FW) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  logic           all_mode,
  input  logic           want_val,
  input  logic           use_cr,
  input  logic [SW-1:0]  bit_sel,
  input  logic           ctr_mode,
  input  logic           ctr_masked,
  input  logic           dec_ctr,
  input  logic           vli_mode,
  input  logic           vli_stop_ok,
  input  logic           vli_incl,
  input  logic           link_en,
  input  logic [CW-1:0]  ctr_in,
  input  logic [AW-1:0]  nia_in,
  input  logic [AW-1:0]  lst_in,
  input  logic [AW-1:0]  llr_in,
  input  logic [FW-1:0]  elem_cr,
  input  logic           elem_pred,
  output logic           busy,
  output logic [VLW-1:0] elem_idx,
  output logic           done,
  output logic           taken,
  output logic           ctr_we,
  output logic [CW-1:0]  ctr_out,
  output logic           vl_we,
  output logic [VLW-1:0] vl_out,
  output logic           lr_we,
  output logic [AW-1:0]  lr_data,
  output logic           llr_we,
  output logic [AW-1:0]  llr_data,
  output logic           lst_we,
  output logic [AW-1:0]  lst_data
);

  logic           run;
  logic [VLW-1:0] idx, vl_q, cnt_q;
  logic           all_q, want_q, usecr_q, cmode_q, cmask_q, dec_q;
  logic           vli_q, stop_q, incl_q, link_q;
  logic [SW-1:0]  bs_q;
  logic [CW-1:0]  ctr_q;
  logic [AW-1:0]  nia_q, lst_q, llr_q;
  logic           all_acc, any_acc;

  logic           empty, act, ok, trig, last, bump;
  logic           all_n, any_n, set_ok, take;
  logic [VLW-1:0] cnt_n;
  logic [CW-1:0]  ctr_new;

  assign busy     = run;
  assign elem_idx = idx;

  assign empty = (idx >= vl_q);
  assign act   = !empty && elem_pred;
  assign ok    = !usecr_q || (elem_cr[bs_q] == want_q);
  assign trig  = act && vli_q && (ok == stop_q);
  assign last  = empty || trig || (VLW'(idx + 1'b1) == vl_q);

  assign all_n = all_acc & (!act | ok);
  assign any_n = any_acc | (act & ok);
  assign bump  = cmode_q && ((act && ok) || (!empty && !elem_pred && cmask_q));
  assign cnt_n = cnt_q + VLW'(bump);

  assign ctr_new = cmode_q ? ctr_q - CW'(cnt_n)
                 : dec_q   ? ctr_q - CW'(1)
                 :           ctr_q;
  assign set_ok  = all_q ? all_n : any_n;
  assign take    = set_ok && (cmode_q || !dec_q || (ctr_new != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; idx <= '0; vl_q <= '0; cnt_q <= '0;
      all_q <= 1'b0; want_q <= 1'b0; usecr_q <= 1'b0; cmode_q <= 1'b0;
      cmask_q <= 1'b0; dec_q <= 1'b0; vli_q <= 1'b0; stop_q <= 1'b0;
      incl_q <= 1'b0; link_q <= 1'b0; bs_q <= '0; ctr_q <= '0;
      nia_q <= '0; lst_q <= '0; llr_q <= '0;
      all_acc <= 1'b1; any_acc <= 1'b0;
    end else if (!run) begin
      if (start) begin
        run     <= 1'b1;
        idx     <= '0;
        cnt_q   <= '0;
        vl_q    <= (vl_in > VLW'(MAXVL)) ? VLW'(MAXVL) : vl_in;
        all_q   <= all_mode;   want_q  <= want_val;  usecr_q <= use_cr;
        cmode_q <= ctr_mode;   cmask_q <= ctr_masked; dec_q  <= dec_ctr;
        vli_q   <= vli_mode;   stop_q  <= vli_stop_ok; incl_q <= vli_incl;
        link_q  <= link_en;    bs_q    <= bit_sel;    ctr_q   <= ctr_in;
        nia_q   <= nia_in;     lst_q   <= lst_in;     llr_q   <= llr_in;
        all_acc <= 1'b1;       any_acc <= 1'b0;
      end
    end else begin
      all_acc <= all_n;
      any_acc <= any_n;
      cnt_q   <= cnt_n;
      idx     <= VLW'(idx + 1'b1);
      if (last) run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; taken <= 1'b0; ctr_we <= 1'b0; ctr_out <= '0;
      vl_we <= 1'b0; vl_out <= '0; lr_we <= 1'b0; lr_data <= '0;
      llr_we <= 1'b0; llr_data <= '0; lst_we <= 1'b0; lst_data <= '0;
    end else begin
      done <= 1'b0; ctr_we <= 1'b0; vl_we <= 1'b0;
      lr_we <= 1'b0; llr_we <= 1'b0; lst_we <= 1'b0;
      if (run && last) begin
        done     <= 1'b1;
        taken    <= take;
        ctr_we   <= cmode_q || dec_q;
        ctr_out  <= ctr_new;
        vl_we    <= trig;
        vl_out   <= trig ? (incl_q ? VLW'(idx + 1'b1) : idx) : vl_q;
        lr_we    <= link_q && take;
        llr_we   <= link_q && take;
        lst_we   <= link_q && take;
        lr_data  <= nia_q;
        llr_data <= lst_q;
        lst_data <= llr_q;
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (elem_idx <= vl_q));
  p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= VLW'(MAXVL));
  p_we_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_we || vl_we) |-> done);
  p_link_paired_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_we || llr_we || lst_we) |-> (lr_we && llr_we && lst_we && done && taken));
  p_vl_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vl_we |-> (vl_out <= vl_q));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> !done);

endmodule

// File: tb/vbranch_eval_bench.sv
`timescale 1ns/1ps
module vbranch_eval_bench;
  localparam int MAXVL = 64, CW = 16, AW = 32, FW = 4;
  localparam int VLW = $clog2(MAXVL + 1);
  localparam int SW  = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [VLW-1:0] vl_in = '0;
  logic all_mode = 0, want_val = 0, use_cr = 1, ctr_mode = 0, ctr_masked = 0;
  logic dec_ctr = 0, vli_mode = 0, vli_stop_ok = 0, vli_incl = 0, link_en = 0;
  logic [SW-1:0] bit_sel = '0;
  logic [CW-1:0] ctr_in = '0;
  logic [AW-1:0] nia_in = '0, lst_in = '0, llr_in = '0;
  logic [FW-1:0] elem_cr;
  logic elem_pred;
  logic busy, done, taken, ctr_we, vl_we, lr_we, llr_we, lst_we;
  logic [VLW-1:0] elem_idx, vl_out;
  logic [CW-1:0] ctr_out;
  logic [AW-1:0] lr_data, llr_data, lst_data;

  logic [FW-1:0] cr_mem [MAXVL];
  logic          pr_mem [MAXVL];
  assign elem_cr   = (elem_idx < VLW'(MAXVL)) ? cr_mem[elem_idx] : '0;
  assign elem_pred = (elem_idx < VLW'(MAXVL)) ? pr_mem[elem_idx] : 1'b0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  vbranch_eval u_vbranch_eval (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [63:0] bits, input logic [63:0] preds);
    for (int i = 0; i < MAXVL; i++) begin
      logic [FW-1:0] f;
      f = FW'($urandom);
      f[bit_sel] = bits[i];
      cr_mem[i] = f;
      pr_mem[i] = preds[i];
    end
  endtask

  task automatic run_op(input string tag, input bit poke);
    int n, lat, dec, nvl;
    bit allok, anyok, trg, e_take, e_cwe, timing_ok;
    logic [CW-1:0] e_ctr;
    int vl;
    bit s_all;
    vl = (int'(vl_in) > MAXVL) ? MAXVL : int'(vl_in);
    allok = 1; anyok = 0; trg = 0; dec = 0; n = vl; nvl = vl;
    for (int i = 0; i < vl; i++) begin
      bit okv;
      okv = !use_cr || (cr_mem[i][bit_sel] == want_val);
      if (!pr_mem[i]) begin
        if (ctr_mode && ctr_masked) dec++;
        continue;
      end
      allok &= okv; anyok |= okv;
      if (ctr_mode && okv) dec++;
      if (vli_mode && okv == vli_stop_ok) begin
        trg = 1; n = i + 1; nvl = vli_incl ? i + 1 : i; break;
      end
    end
    e_cwe = ctr_mode || dec_ctr;
    e_ctr = ctr_mode ? ctr_in - CW'(dec) : dec_ctr ? ctr_in - 1 : ctr_in;
    e_take = (all_mode ? allok : anyok) && (ctr_mode || !dec_ctr || e_ctr != 0);
    lat = (n == 0) ? 1 : n;
    s_all = all_mode;

    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    timing_ok = 1;
    if (busy !== 1'b1) timing_ok = 0;
    if (lat > 0 && n > 0 && elem_idx !== 0) timing_ok = 0;
    if (poke) begin start = 1'b1; vl_in = '0; all_mode = ~s_all; end
    for (int m = 1; m <= lat; m++) begin
      @(posedge clk); #1;
      if (poke) begin start = 1'b0; all_mode = s_all; end
      if (done !== (m == lat)) timing_ok = 0;
      if (m < lat && elem_idx !== VLW'(m)) timing_ok = 0;
    end
    chk({tag, " R9 timing"}, timing_ok, 1);
    chk({tag, " R2/R3 taken"}, taken, e_take);
    chk({tag, " R7 ctr"}, {ctr_we, ctr_out}, {e_cwe, e_ctr});
    chk({tag, " R6 vl"}, {vl_we, vl_out}, {trg, VLW'(nvl)});
    chk({tag, " R8 link"}, {lr_we, llr_we, lst_we},
        {3{link_en && e_take}});
    if (link_en && e_take)
      chk({tag, " R8 swap"}, {lr_data, llr_data, lst_data}, {nia_in, lst_in, llr_in});
    @(posedge clk); #1;
    chk({tag, " R9 done pulse"}, done, 0);
  endtask

  task automatic cfg(input bit a, input bit w, input int vl);
    all_mode = a; want_val = w; vl_in = VLW'(vl);
    use_cr = 1; ctr_mode = 0; ctr_masked = 0; dec_ctr = 0;
    vli_mode = 0; vli_stop_ok = 0; vli_incl = 0; link_en = 0;
  endtask

  initial begin
    for (int i = 0; i < MAXVL; i++) begin cr_mem[i] = '0; pr_mem[i] = 1'b1; end
    #1;
    chk("R10 reset", {busy, done, ctr_we, vl_we, lr_we, llr_we, lst_we}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 after reset", {busy, done, ctr_we, vl_we, lr_we}, 0);

    bit_sel = 2;
    cfg(1, 1, 4); fill(64'hF, '1);  run_op("R1 R2 all-pass", 0);
    cfg(1, 1, 4); fill(64'hB, '1);  run_op("R2 all-pass one fails", 0);
    cfg(1, 0, 4); fill(64'h0, '1);  run_op("R2 all-fail", 0);
    cfg(0, 1, 5); fill(64'h4, '1);  run_op("R3 some-pass", 0);
    cfg(0, 1, 5); fill(64'h0, '1);  run_op("R3 some none", 0);
    cfg(0, 0, 5); fill(64'h1F, '1); run_op("R3 some-fail none", 0);
    cfg(1, 1, 4); fill(64'hB, 64'hB); run_op("R4 masked fail", 0);
    cfg(0, 1, 4); fill(64'h4, 64'hB); run_op("R4 masked pass", 0);
    cfg(1, 1, 6); fill(64'h0, 64'h0); run_op("R2 empty all", 0);
    cfg(0, 1, 6); fill(64'hFF, 64'h0); run_op("R3 empty some", 0);
    cfg(1, 1, 0); run_op("R9 zero length", 0);
    bit_sel = 1;
    cfg(1, 1, 1); fill(64'h1, '1); run_op("R5 scalar taken", 0);
    cfg(1, 0, 1); fill(64'h1, '1); run_op("R5 scalar sense", 0);
    cfg(1, 1, 1); fill(64'h1, '1); dec_ctr = 1; ctr_in = 1; run_op("R5 ctr hits zero", 0);
    cfg(1, 1, 1); fill(64'h1, '1); dec_ctr = 1; ctr_in = 5; run_op("R5 ctr nonzero", 0);
    cfg(1, 1, 1); fill(64'h0, '1); use_cr = 0; ctr_in = 0; run_op("R1 no cr test", 0);
    cfg(0, 1, 10); fill(64'h3DF, '1); vli_mode = 1; vli_stop_ok = 0; run_op("R6 stop on fail", 0);
    cfg(0, 1, 10); fill(64'h3DF, '1); vli_mode = 1; vli_stop_ok = 0; vli_incl = 1; run_op("R6 stop incl", 0);
    cfg(1, 1, 10); fill(64'h100, 64'h3F3); vli_mode = 1; vli_stop_ok = 1; vli_incl = 1;
    ctr_mode = 1; ctr_masked = 1; ctr_in = 40; link_en = 1;
    nia_in = 32'h1000; lst_in = 32'hA5; llr_in = 32'h5A;
    fill(64'h10C, 64'h3F3); run_op("R6 masked not stop", 0);
    cfg(1, 1, 8); fill(64'hFF, '1); vli_mode = 1; vli_stop_ok = 0; run_op("R6 no trigger", 0);
    cfg(0, 1, 12); fill(64'h0A5, 64'hF0F); ctr_mode = 1; ctr_in = 100; dec_ctr = 1; run_op("R7 counted", 0);
    cfg(0, 1, 12); fill(64'h0A5, 64'hF0F); ctr_mode = 1; ctr_masked = 1; ctr_in = 3; run_op("R7 counted masked wrap", 0);
    cfg(0, 1, 4); fill(64'h2, '1); link_en = 1; nia_in = 32'h2004; lst_in = 32'h11; llr_in = 32'h22;
    run_op("R8 link taken", 0);
    cfg(0, 1, 4); fill(64'h0, '1); link_en = 1; run_op("R8 link not taken", 0);
    cfg(1, 1, 6); fill(64'h3F, '1); run_op("R9 start while busy", 1);
    cfg(0, 0, 100); fill('1, '1); run_op("R9 clamp", 0);

    for (int t = 0; t < 40; t++) begin
      bit_sel = SW'($urandom);
      cfg($urandom % 2, $urandom % 2, $urandom % 13);
      use_cr = ($urandom % 5) != 0; ctr_mode = $urandom % 2; ctr_masked = $urandom % 2;
      dec_ctr = $urandom % 2; vli_mode = $urandom % 2; vli_stop_ok = $urandom % 2;
      vli_incl = $urandom % 2; link_en = $urandom % 2; ctr_in = CW'($urandom % 8);
      nia_in = $urandom; lst_in = $urandom; llr_in = $urandom;
      fill({$urandom, $urandom}, {$urandom, $urandom});
      run_op("R1 R2 R3 R4 R6 R7 random", t % 7 == 3);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule